// File: doc/BRIEF.md
# Match-Control Timer

A general-purpose up-counting timer with seven match channels. A prescale counter divides the clock. Each time it wraps, the main timer count advances by one. On that advance the current timer count is compared against every channel's match value. A channel that matches can raise a sticky interrupt flag, zero the counters, or halt the timer. Each of these actions has its own enable bit, so one channel can combine any of the three.

Software reaches the block through a small word-wide register port. Writes are single-cycle and reads are combinational. The port gives access to the run and hold controls, the counting-mode field, the prescale limit, the match values, the per-channel action bits and the flag register. Flags are cleared by writing ones to them. A halt clears the run bit itself, so software restarts the timer by setting the run bit again. The single interrupt output is level-sensitive and is the OR of every flag whose channel interrupt enable is set.

Top module: `match_timer`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: Register map (4-bit word address). Control at 0x0 has bit 0 = run, bit 1 = hold and bits 4:2 = counting mode. The prescale limit is at 0x1 (read/write). The timer count is at 0x2 and the prescale count at 0x3 (both read-only). Channel actions are at 0x4, with channel i at bit 3i = interrupt enable, bit 3i+1 = reset enable and bit 3i+2 = stop enable; a 1 enables an action and a 0 disables it. Flags are at 0x5, with bit i for channel i. The match value of channel i is at 0x8+i.
- R3: While run is 1, the prescale count steps 0 to the limit L and then wraps to 0. On each wrap (a tick) the timer count advances by one, so it advances once every L+1 clocks. While run is 0 both counts hold.
- R4: On a tick where the timer count equals the match value of a channel with stop enabled, both counts halt and the run bit clears. The timer count keeps the matched value.
- R5: On a tick where the timer count equals the match value of a channel with reset enabled, the timer count and the prescale count load zero.
- R6: When several channels match on one tick, all their actions apply together. A stop overrides a reset.
- R7: On a tick where a channel with interrupt enable matches and the mode is 000, that channel's flag sets. The flag stays set until a 1 is written to its bit. If a set and a clear fall in the same cycle, the set wins.
- R8: `irq` is high exactly when some flag is set whose channel interrupt enable is 1.
- R9: While hold is 1, both counts are held at zero.
- R10: Writing run = 1 after a stop resumes counting from the held count.
- R11: With a mode other than 000, matches set no flags, but reset and stop still act.
- R12: A match on a channel whose three action bits are 0 has no effect. Writing 0 to a flag bit leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr` (combinational) |
| irq | output | 1 | Combined level interrupt |

## Verification
The counter reset and the counter halt can both be triggered on the same tick by two different channels. This is provoked by giving channel 0 a reset action and channel 1 a stop action at the same match value. The result is judged by the timer count staying at that value rather than returning to zero, with the run bit found cleared. A second collision in one cycle is between a flag being set by a match and a write-one-to-clear of that same flag. The clear write is timed onto the matching tick, and the flag must still read as set afterwards.

// File: rtl/mt_pkg.sv
package mt_pkg;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] A_CTRL    = 4'h0;
  localparam logic [ADDR_W-1:0] A_PRE_LIM = 4'h1;
  localparam logic [ADDR_W-1:0] A_TCOUNT  = 4'h2;
  localparam logic [ADDR_W-1:0] A_PCOUNT  = 4'h3;
  localparam logic [ADDR_W-1:0] A_ACTIONS = 4'h4;
  localparam logic [ADDR_W-1:0] A_FLAGS   = 4'h5;
  localparam int               A_MATCH0  = 8;
  localparam int               MODE_W    = 3;
  localparam logic [MODE_W-1:0] MODE_UP  = 3'b000;
  // per-channel action bits, msb first: stop, reset, interrupt enable
  typedef struct packed {
    logic stop;
    logic rst;
    logic ien;
  } chan_ctl_t;
endpackage

// File: rtl/mt_rst_sync.sv
module mt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/mt_prescaler.sv
module mt_prescaler #(
  parameter int PRE_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             count_en,
  input  logic             clear,
  input  logic [PRE_W-1:0] limit,
  output logic [PRE_W-1:0] pcount,
  output logic             tick
);
  logic [PRE_W-1:0] cnt_q, cnt_d;
  logic             cnt_ce;

  // >= so that lowering the limit below the count still wraps
  assign tick   = count_en && !clear && (cnt_q >= limit);
  assign cnt_ce = clear || count_en;

  always_comb begin
    cnt_d = cnt_q;
    if (clear)     cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  assign pcount = cnt_q;
endmodule

// File: rtl/mt_match_unit.sv
module mt_match_unit import mt_pkg::*; #(
  parameter int CNT_W = 32
) (
  input  logic [CNT_W-1:0] tcount,
  input  logic [CNT_W-1:0] match_val,
  input  chan_ctl_t        ctl,
  input  logic             tick,
  input  logic             irq_ok,
  output logic             hit_irq,
  output logic             hit_rst,
  output logic             hit_stop
);
  logic hit;

  assign hit      = tick && (tcount == match_val);
  assign hit_irq  = hit && ctl.ien && irq_ok;
  assign hit_rst  = hit && ctl.rst;
  assign hit_stop = hit && ctl.stop;
endmodule

// File: rtl/mt_flag_bank.sv
module mt_flag_bank #(
  parameter int NUM_CH = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] set_vec,
  input  logic [NUM_CH-1:0] clr_vec,
  input  logic [NUM_CH-1:0] ien_vec,
  output logic [NUM_CH-1:0] flags,
  output logic              irq
);
  logic [NUM_CH-1:0] flag_q, flag_d;
  logic              flag_ce;

  assign flag_ce = |set_vec || |clr_vec;

  // set has priority over a simultaneous clear
  always_comb begin
    flag_d = (flag_q & ~clr_vec) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= '0;
    else if (flag_ce) flag_q <= flag_d;
  end

  assign flags = flag_q;
  assign irq   = |(flag_q & ien_vec);
endmodule

// File: rtl/match_timer.sv
module match_timer import mt_pkg::*; #(
  parameter int DATA_W = 32,
  parameter int PRE_W  = 16,
  parameter int NUM_CH = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  localparam int CTL_BITS = 3 * NUM_CH;

  logic rst_sync_n;

  logic              run_q, run_d, hold_q, hold_d;
  logic [MODE_W-1:0] mode_q, mode_d;
  logic [PRE_W-1:0]  prelim_q, prelim_d;
  logic [CTL_BITS-1:0] act_q, act_d;
  logic [DATA_W-1:0] mval_q [NUM_CH];
  logic [DATA_W-1:0] mval_d [NUM_CH];
  logic [DATA_W-1:0] tcount_q, tcount_d;

  logic              ctrl_wr, prelim_wr, act_wr, flags_wr;
  logic [NUM_CH-1:0] mval_wr;
  logic              tick, mode_ok, any_stop, any_rst;
  logic [PRE_W-1:0]  pcount;
  logic [NUM_CH-1:0] hit_irq, hit_rst, hit_stop, ien_vec, flags, clr_vec;

  mt_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  // write decode
  assign ctrl_wr   = reg_wr && (reg_addr == A_CTRL);
  assign prelim_wr = reg_wr && (reg_addr == A_PRE_LIM);
  assign act_wr    = reg_wr && (reg_addr == A_ACTIONS);
  assign flags_wr  = reg_wr && (reg_addr == A_FLAGS);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_wdec
    assign mval_wr[g] = reg_wr && (reg_addr == ADDR_W'(A_MATCH0 + g));
  end

  mt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_sync_n), .count_en(run_q), .clear(hold_q),
    .limit(prelim_q), .pcount(pcount), .tick(tick)
  );

  assign mode_ok = (mode_q == MODE_UP);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    mt_match_unit #(.CNT_W(DATA_W)) u_mu (
      .tcount(tcount_q), .match_val(mval_q[g]), .ctl(act_q[3*g +: 3]),
      .tick(tick), .irq_ok(mode_ok),
      .hit_irq(hit_irq[g]), .hit_rst(hit_rst[g]), .hit_stop(hit_stop[g])
    );
    assign ien_vec[g] = act_q[3*g];
  end

  assign any_stop = |hit_stop;
  assign any_rst  = |hit_rst;
  assign clr_vec  = flags_wr ? reg_wdata[NUM_CH-1:0] : '0;

  mt_flag_bank #(.NUM_CH(NUM_CH)) u_flags (
    .clk(clk), .rst_n(rst_sync_n), .set_vec(hit_irq), .clr_vec(clr_vec),
    .ien_vec(ien_vec), .flags(flags), .irq(irq)
  );

  // next-state logic
  always_comb begin
    run_d    = run_q;
    hold_d   = hold_q;
    mode_d   = mode_q;
    prelim_d = prelim_q;
    act_d    = act_q;
    if (ctrl_wr) begin
      run_d  = reg_wdata[0];
      hold_d = reg_wdata[1];
      mode_d = reg_wdata[2 +: MODE_W];
    end else if (any_stop) begin
      run_d  = 1'b0;
    end
    if (prelim_wr) prelim_d = reg_wdata[PRE_W-1:0];
    if (act_wr)    act_d    = reg_wdata[CTL_BITS-1:0];
    for (int i = 0; i < NUM_CH; i++) begin
      mval_d[i] = mval_wr[i] ? reg_wdata : mval_q[i];
    end
  end

  always_comb begin
    tcount_d = tcount_q;
    if (hold_q)          tcount_d = '0;
    else if (tick) begin
      if (any_stop)      tcount_d = tcount_q;
      else if (any_rst)  tcount_d = '0;
      else               tcount_d = tcount_q + 1'b1;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      run_q    <= 1'b0;
      hold_q   <= 1'b0;
      mode_q   <= '0;
      prelim_q <= '0;
      act_q    <= '0;
      tcount_q <= '0;
      for (int i = 0; i < NUM_CH; i++) mval_q[i] <= '0;
    end else begin
      if (ctrl_wr || any_stop) begin
        run_q  <= run_d;
        hold_q <= hold_d;
        mode_q <= mode_d;
      end
      if (prelim_wr) prelim_q <= prelim_d;
      if (act_wr)    act_q    <= act_d;
      if (hold_q || tick) tcount_q <= tcount_d;
      for (int i = 0; i < NUM_CH; i++) begin
        if (mval_wr[i]) mval_q[i] <= mval_d[i];
      end
    end
  end

  // read mux
  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:    begin
                   reg_rdata[0] = run_q;
                   reg_rdata[1] = hold_q;
                   reg_rdata[2 +: MODE_W] = mode_q;
                 end
      A_PRE_LIM: reg_rdata[PRE_W-1:0]    = prelim_q;
      A_TCOUNT:  reg_rdata               = tcount_q;
      A_PCOUNT:  reg_rdata[PRE_W-1:0]    = pcount;
      A_ACTIONS: reg_rdata[CTL_BITS-1:0] = act_q;
      A_FLAGS:   reg_rdata[NUM_CH-1:0]   = flags;
      default: begin
        for (int i = 0; i < NUM_CH; i++) begin
          if (reg_addr == ADDR_W'(A_MATCH0 + i)) reg_rdata = mval_q[i];
        end
      end
    endcase
  end
endmodule

// File: rtl/mt_checker.sv
module mt_checker #(
  parameter int CNT_W  = 32,
  parameter int PRE_W  = 16,
  parameter int NUM_CH = 7
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              tick,
  input logic              any_stop,
  input logic              any_rst,
  input logic              run_q,
  input logic              hold_q,
  input logic              ctrl_wr,
  input logic              flags_wr,
  input logic [CNT_W-1:0]  tcount_q,
  input logic [PRE_W-1:0]  pcount,
  input logic [NUM_CH-1:0] flags
);
  AST_STOP_CLEARS_RUN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (tick && any_stop && !ctrl_wr) |=> !run_q); // R4
  AST_STOP_FREEZES: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (tick && any_stop && !hold_q) |=> (tcount_q == $past(tcount_q))); // R4
  AST_STOP_OVER_RESET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (tick && any_stop && any_rst) |=> (tcount_q == $past(tcount_q))); // R6
  AST_RESET_ZEROES: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (tick && any_rst && !any_stop) |=> (tcount_q == '0 && pcount == '0)); // R5
  AST_HOLD_ZEROES: assert property (@(posedge clk) disable iff (!rst_sync_n)
    hold_q |=> (tcount_q == '0 && pcount == '0)); // R9
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!run_q && !hold_q) |=> $stable(tcount_q)); // R3
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !flags_wr |=> ((flags & $past(flags)) == $past(flags))); // R7
endmodule

bind match_timer mt_checker #(.CNT_W(DATA_W), .PRE_W(PRE_W), .NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .tick(tick), .any_stop(any_stop),
  .any_rst(any_rst), .run_q(run_q), .hold_q(hold_q), .ctrl_wr(ctrl_wr),
  .flags_wr(flags_wr), .tcount_q(tcount_q), .pcount(pcount), .flags(flags)
);

// File: tb/sim_match_timer.sv
module sim_match_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk; // 125 MHz

  match_timer u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wait_edges(input int k);
    repeat (k) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; reg_wr = 1'b0;
    wait_edges(2);
    rst_n = 1'b1;
    wait_edges(3);
  endtask

  task automatic t_reset_state();
    logic [31:0] d;
    do_reset();
    rd(4'h0, d); chk("R1 ctrl", d, 0);
    rd(4'h2, d); chk("R1 tcount", d, 0);
    rd(4'h5, d); chk("R1 flags", d, 0);
    chk("R1 irq", {31'd0, irq}, 0);
  endtask

  task automatic t_regmap();
    logic [31:0] d;
    wr(4'hE, 32'h1234_5678);
    wr(4'h1, 32'h0000_00A5);
    rd(4'hE, d); chk("R2 match6 readback", d, 32'h1234_5678);
    rd(4'h1, d); chk("R2 prescale limit readback", d, 32'hA5);
    rd(4'h8, d); chk("R2 match0 untouched", d, 0);
  endtask

  task automatic t_prescale();
    logic [31:0] d;
    do_reset();
    wr(4'h1, 3);
    wr(4'h0, 1);
    wait_edges(6);
    rd(4'h2, d); chk("R3 tcount after 6 clocks, limit 3", d, 1);
    rd(4'h3, d); chk("R3 pcount after 6 clocks", d, 2);
    wr(4'h0, 0);
    wait_edges(5);
    rd(4'h2, d); chk("R3 tcount holds when run=0", d, 1);
    rd(4'h3, d); chk("R3 pcount holds when run=0", d, 3);
  endtask

  task automatic t_stop_restart();
    logic [31:0] d;
    do_reset();
    wr(4'h8, 5);
    wr(4'h4, 32'h4);       // ch0 stop
    wr(4'h0, 1);
    wait_edges(10);
    rd(4'h2, d); chk("R4 tcount frozen at match", d, 5);
    rd(4'h0, d); chk("R4 run cleared by stop", d, 0);
    wr(4'h8, 100);
    wr(4'h0, 1);
    wait_edges(4);
    rd(4'h2, d); chk("R10 resumed from held count", d, 9);
  endtask

  task automatic t_reset_match();
    logic [31:0] d;
    do_reset();
    wr(4'h9, 3);
    wr(4'h4, 32'h10);      // ch1 reset
    wr(4'h0, 1);
    wait_edges(10);
    rd(4'h2, d); chk("R5 tcount wraps through zero", d, 2);
  endtask

  task automatic t_stop_vs_reset();
    logic [31:0] d;
    do_reset();
    wr(4'h8, 3);
    wr(4'h9, 3);
    wr(4'h4, 32'h22);      // ch0 reset, ch1 stop
    wr(4'h0, 1);
    wait_edges(10);
    rd(4'h2, d); chk("R6 stop beats reset on same tick", d, 3);
    rd(4'h0, d); chk("R6 run cleared", d, 0);
  endtask

  task automatic t_irq_and_mask();
    logic [31:0] d;
    do_reset();
    wr(4'hA, 4);
    wr(4'h4, 32'hC0);      // ch2 interrupt + reset
    wr(4'h0, 1);
    wait_edges(12);
    rd(4'h2, d); chk("R6 reset applied with interrupt", d, 2);
    rd(4'h5, d); chk("R7 flag set by match", d, 32'h4);
    chk("R8 irq high", {31'd0, irq}, 1);
    wr(4'h0, 0);
    wr(4'h5, 0);
    rd(4'h5, d); chk("R12 writing 0 keeps flag", d, 32'h4);
    wr(4'h4, 32'h80);      // interrupt enable off
    #1; chk("R8 irq masked by enable", {31'd0, irq}, 0);
    rd(4'h5, d); chk("R8 flag still set while masked", d, 32'h4);
    wr(4'h5, 32'h4);
    rd(4'h5, d); chk("R7 write-one clears flag", d, 0);
  endtask

  task automatic t_set_beats_clear();
    logic [31:0] d;
    do_reset();
    wr(4'hB, 2);
    wr(4'h4, 32'h200);     // ch3 interrupt
    wr(4'h0, 1);
    wait_edges(2);
    wr(4'h5, 32'h8);       // lands on the matching tick
    rd(4'h5, d); chk("R7 set wins over same-cycle clear", d, 32'h8);
    wr(4'h5, 32'h8);
    rd(4'h5, d); chk("R7 later clear takes effect", d, 0);
  endtask

  task automatic t_mode_reserved();
    logic [31:0] d;
    do_reset();
    wr(4'h8, 2);
    wr(4'h4, 32'h5);       // ch0 interrupt + stop
    wr(4'h0, 32'h5);       // run, mode 001
    wait_edges(10);
    rd(4'h5, d); chk("R11 no flag in reserved mode", d, 0);
    rd(4'h2, d); chk("R11 stop still acts", d, 2);
    rd(4'h0, d); chk("R11 mode kept, run cleared", d, 32'h4);
    chk("R11 irq low", {31'd0, irq}, 0);
  endtask

  task automatic t_hold();
    logic [31:0] d;
    do_reset();
    wr(4'h1, 2);
    wr(4'h0, 3);           // run + hold
    wait_edges(5);
    rd(4'h2, d); chk("R9 tcount held at zero", d, 0);
    rd(4'h3, d); chk("R9 pcount held at zero", d, 0);
    wr(4'h0, 1);
    wait_edges(7);
    rd(4'h2, d); chk("R9 counts after hold release", d, 2);
  endtask

  task automatic t_no_action();
    logic [31:0] d;
    do_reset();
    wr(4'hC, 3);           // ch4 value, no action bits
    wr(4'h0, 1);
    wait_edges(8);
    rd(4'h2, d); chk("R12 inert channel passes", d, 8);
    rd(4'h5, d); chk("R12 inert channel no flag", d, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset_state();
    t_regmap();
    t_prescale();
    t_stop_restart();
    t_reset_match();
    t_stop_vs_reset();
    t_irq_and_mask();
    t_set_beats_clear();
    t_mode_reserved();
    t_hold();
    t_no_action();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule